// File: doc/BRIEF.md
# Serial Peripheral Port Controller

This block is an 8-bit serial peripheral controller that sits on a small register bus with three registers: control, status and data. As the clock-driving end of the link it makes the serial clock from the system clock through a divider picked from an eight-entry table, and shifts one byte out and one byte in, most significant bit first. Either clock phase and either idle level can be selected. As the clock-receiving end it brings the external clock, data and select pins into the system clock domain and shifts on the detected edges.

Software learns of a finished byte through a completion flag, which also drives an interrupt request. That request is gated by an enable bit and by a global enable input. A write to the data register while a byte is moving raises a collision flag. It does not disturb the byte in flight. Both flags clear only after two steps: a status read that sees the flag set, then any access to the data register. When the controller drives the clock and is told to watch its select pin, a low level on that pin is taken as a bus conflict: the completion flag sets and the block drops out of clock-driving mode.

Top module: `sspi_periph`

## Requirements
- R1: After reset the control register (address 0), status register (address 1) and the bus read data are all zero, `sck_o` is low and `irq` is low.
- R2: In clock-driving mode the `sck_o` period in system clocks is set by {status bit 0, control bits 1:0}: 000 gives 4, 001 gives 16, 010 gives 64, 011 gives 128, 100 gives 2, 101 gives 8, 110 gives 32, 111 gives 64.
- R3: Outside a transfer, `sck_o` rests at the level of the clock-polarity bit (control bit 3).
- R4: With control bit 6 (enable) and bit 4 (clock-driving) set and no transfer running, a write to the data register (address 2) shifts that byte out on `mosi_o` MSB first and captures 8 bits from `miso_i`. With control bit 2 (phase) clear, data is sampled on the leading clock edge and changed on the trailing one. With the bit set, data is changed on the leading edge and sampled on the trailing one. A data read returns the received byte.
- R5: Status bit 7 (completion) sets when a byte finishes.
- R6: An access to the data register clears the completion and collision flags only if a status read that saw that flag set came before it. A data access without that status read leaves the flags set.
- R7: A data write during a transfer sets status bit 6 (collision). The byte being shifted and the byte received are not affected.
- R8: Status bits 5 to 1 always read zero. Of the status bits, only bit 0 (double speed) takes a bus write.
- R9: `irq` is high one cycle after completion, control bit 7 (interrupt enable) and `glob_irq_en` are all high, and low otherwise. A pulse on `irq_ack` clears the completion flag.
- R10: With clock-driving mode and control bit 5 (select watch) set, a low on `ss_n_i` sets the completion flag, clears control bit 4 and stops the clock.
- R11: With control bit 4 clear and `ss_n_i` low, the block shifts on edges of `sck_i` using the same phase and polarity rules. It receives the byte on `mosi_i` and sends the byte last written to the data register on `miso_o`, MSB first. The rate bits have no effect in this mode.
- R12: In clock-receiving mode, raising `ss_n_i` drops a partly received byte without setting the completion flag, and the next byte is received from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| glob_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in clock-driving mode |
| mosi_o | output | 1 | Serial data out in clock-driving mode |
| miso_i | input | 1 | Serial data in, clock-driving mode |
| ss_n_i | input | 1 | Select input, active low |
| sck_i | input | 1 | Serial clock in, clock-receiving mode |
| mosi_i | input | 1 | Serial data in, clock-receiving mode |
| miso_o | output | 1 | Serial data out, clock-receiving mode |

## Verification
On every cycle, assertions check the rules that need no knowledge of the data. The clock stays at its idle level outside a transfer. The collision flag rises only after a data write. The completion flag falls only after an acknowledge or a data access. The reserved status bits read zero, the request stays low while the global enable is low, the bit counter finishes only on a trailing edge, and the divider ticks are spaced correctly. The scenarios show what depends on values and sequences. These are the divider table, the bit order under each phase and polarity, the two-step flag clear, an intact byte after a collision, the select-watch fault, and receiving-mode shifting with a transfer dropped partway.

// File: rtl/sspi_pkg.sv
package sspi_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       ss_watch;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // log2 of the half period in system clocks
  function automatic logic [2:0] half_log2(input logic dbl, input logic [1:0] rate);
    logic [2:0] base;
    case (rate)
      2'd0:    base = 3'd1;
      2'd1:    base = 3'd3;
      2'd2:    base = 3'd5;
      default: base = 3'd6;
    endcase
    return base - {2'b00, dbl};
  endfunction

endpackage

// File: rtl/sspi_rate_gen.sv
module sspi_rate_gen #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] half_log,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = (CNT_W'(1) << half_log) - CNT_W'(1);
  assign tick_o = run && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= '0;
    else if (cnt_q >= limit) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o && half_log != 3'd0 |=> !tick_o || half_log == 3'd0);

endmodule

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic ss_n_i,
  output logic sck_s,
  output logic mosi_s,
  output logic ss_n_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] mosi_p;
  logic [STAGES-1:0] ss_p;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      mosi_p <= '0;
      ss_p   <= '1;
    end else begin
      sck_p[0]  <= sck_i;
      mosi_p[0] <= mosi_i;
      ss_p[0]   <= ss_n_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        sck_p[g]  <= 1'b0;
        mosi_p[g] <= 1'b0;
        ss_p[g]   <= 1'b1;
      end else begin
        sck_p[g]  <= sck_p[g-1];
        mosi_p[g] <= mosi_p[g-1];
        ss_p[g]   <= ss_p[g-1];
      end
    end
  end

  assign sck_s  = sck_p[STAGES-1];
  assign mosi_s = mosi_p[STAGES-1];
  assign ss_n_s = ss_p[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

endmodule

// File: rtl/sspi_shift_core.sv
module sspi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              cpha_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] sr_o,
  output logic              out_o,
  output logic              done_o,
  output logic              active_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] sr_next;
  logic [CNT_W-1:0]  cnt_q;
  logic              samp_q;

  assign sr_next  = {sr_q[DATA_W-2:0], (cpha_i ? din_i : samp_q)};
  assign last_o   = (cnt_q == LAST);
  assign sr_o     = sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      samp_q   <= 1'b0;
      out_o    <= 1'b0;
      done_o   <= 1'b0;
      active_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        sr_q     <= load_data;
        out_o    <= load_data[DATA_W-1];
        cnt_q    <= '0;
        active_o <= 1'b0;
      end else if (clear) begin
        cnt_q    <= '0;
        active_o <= 1'b0;
      end else if (lead_i) begin
        active_o <= 1'b1;
        if (!cpha_i) samp_q <= din_i;
        else         out_o  <= sr_q[DATA_W-1];
      end else if (trail_i) begin
        sr_q <= sr_next;
        if (!cpha_i) out_o <= sr_q[DATA_W-2];
        if (last_o) begin
          cnt_q    <= '0;
          done_o   <= 1'b1;
          active_o <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R5
  done_after_trail_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(trail_i));

endmodule

// File: rtl/sspi_periph.sv
module sspi_periph #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_CNT_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  input  logic              glob_irq_en,
  output logic              irq,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o
);
  import sspi_pkg::*;

  localparam int RSV_W = DATA_W - 3;

  ctrl_t             ctrl_q;
  logic              dbl_q, spif_q, wcol_q, arm_spif_q, arm_wcol_q;
  logic [DATA_W-1:0] rx_q;
  logic              mst_busy_q, sck_q;

  logic ctrl_wr, stat_wr, stat_rd, data_wr, data_acc;
  logic en, is_master, mode_fault, xfer_busy, core_load, core_clear;
  logic rate_tick, mst_lead, mst_trail, slv_on, slv_lead, slv_trail;
  logic sck_s, mosi_s, ss_n_s, sck_rise, sck_fall;
  logic [DATA_W-1:0] core_sr;
  logic core_out, core_done, core_active, core_last;

  assign ctrl_wr  = bus_wr && bus_addr == REG_CTRL;
  assign stat_wr  = bus_wr && bus_addr == REG_STAT;
  assign stat_rd  = bus_rd && bus_addr == REG_STAT;
  assign data_wr  = bus_wr && bus_addr == REG_DATA;
  assign data_acc = (bus_wr || bus_rd) && bus_addr == REG_DATA;

  assign en         = ctrl_q.enable;
  assign is_master  = ctrl_q.master;
  assign mode_fault = en && is_master && ctrl_q.ss_watch && !ss_n_s;
  assign xfer_busy  = is_master ? mst_busy_q : core_active;
  assign core_load  = data_wr && en && !xfer_busy;
  assign core_clear = !en || mode_fault || (!is_master && ss_n_s);

  assign mst_lead  = rate_tick && mst_busy_q && (sck_q == ctrl_q.cpol);
  assign mst_trail = rate_tick && mst_busy_q && (sck_q != ctrl_q.cpol);
  assign slv_on    = en && !is_master && !ss_n_s;
  assign slv_lead  = slv_on && (ctrl_q.cpol ? sck_fall : sck_rise);
  assign slv_trail = slv_on && (ctrl_q.cpol ? sck_rise : sck_fall);

  sspi_rate_gen #(.CNT_W(DIV_CNT_W)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .run      (mst_busy_q),
    .half_log (half_log2(dbl_q, ctrl_q.rate)),
    .tick_o   (rate_tick)
  );

  sspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck_i    (sck_i),
    .mosi_i   (mosi_i),
    .ss_n_i   (ss_n_i),
    .sck_s    (sck_s),
    .mosi_s   (mosi_s),
    .ss_n_s   (ss_n_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  sspi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .clear     (core_clear),
    .load      (core_load),
    .load_data (bus_wdata),
    .lead_i    (is_master ? mst_lead : slv_lead),
    .trail_i   (is_master ? mst_trail : slv_trail),
    .cpha_i    (ctrl_q.cpha),
    .din_i     (is_master ? miso_i : mosi_s),
    .sr_o      (core_sr),
    .out_o     (core_out),
    .done_o    (core_done),
    .active_o  (core_active),
    .last_o    (core_last)
  );

  // clock generation in clock-driving mode
  always_ff @(posedge clk) begin
    if (rst) begin
      mst_busy_q <= 1'b0;
      sck_q      <= 1'b0;
    end else begin
      if (!en || mode_fault)           mst_busy_q <= 1'b0;
      else if (core_load && is_master) mst_busy_q <= 1'b1;
      else if (mst_trail && core_last) mst_busy_q <= 1'b0;

      if (!mst_busy_q)    sck_q <= ctrl_q.cpol;
      else if (rate_tick) sck_q <= ~sck_q;
    end
  end

  // registers and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      dbl_q      <= 1'b0;
      spif_q     <= 1'b0;
      wcol_q     <= 1'b0;
      arm_spif_q <= 1'b0;
      arm_wcol_q <= 1'b0;
      rx_q       <= '0;
      irq        <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
      if (mode_fault) ctrl_q.master <= 1'b0;
      if (stat_wr) dbl_q <= bus_wdata[0];
      if (core_done) rx_q <= core_sr;

      if (stat_rd) begin
        arm_spif_q <= spif_q;
        arm_wcol_q <= wcol_q;
      end else if (data_acc) begin
        arm_spif_q <= 1'b0;
        arm_wcol_q <= 1'b0;
      end else begin
        arm_spif_q <= arm_spif_q & spif_q;
        arm_wcol_q <= arm_wcol_q & wcol_q;
      end

      if (core_done || mode_fault)                       spif_q <= 1'b1;
      else if (irq_ack || (data_acc && arm_spif_q))      spif_q <= 1'b0;

      if (data_wr && en && xfer_busy)                    wcol_q <= 1'b1;
      else if (data_acc && arm_wcol_q)                   wcol_q <= 1'b0;

      irq <= spif_q && ctrl_q.irq_en && glob_irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        REG_CTRL: bus_rdata <= DATA_W'(ctrl_q);
        REG_STAT: bus_rdata <= {spif_q, wcol_q, {RSV_W{1'b0}}, dbl_q};
        REG_DATA: bus_rdata <= rx_q;
        default:  bus_rdata <= '0;
      endcase
    end else bus_rdata <= '0;
  end

  assign sck_o  = sck_q;
  assign mosi_o = is_master & core_out;
  assign miso_o = ~is_master & core_out;

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mst_busy_q && $past(!mst_busy_q) && $stable(ctrl_q.cpol) |-> sck_o == ctrl_q.cpol);

  // R7
  wcol_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol_q) |-> $past(bus_wr && bus_addr == REG_DATA));

  // R6
  spif_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spif_q) |-> $past(irq_ack || ((bus_rd || bus_wr) && bus_addr == REG_DATA)));

  // R8
  stat_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == REG_STAT) |-> bus_rdata[DATA_W-3:1] == '0);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_irq_en && $past(!glob_irq_en) |-> !irq);

endmodule

// File: tb/sspi_periph_bench.sv
module sspi_periph_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0, glob_irq_en = 1'b0, irq;
  logic       sck_o, mosi_o, miso_i;
  logic       ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, miso_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign miso_i = mosi_o;   // loopback for clock-driving tests

  sspi_periph u_sspi_periph (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .glob_irq_en(glob_irq_en), .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .ss_n_i(ss_n_i), .sck_i(sck_i), .mosi_i(mosi_i), .miso_o(miso_o)
  );

  // line monitor: bits on sampling edges and leading-edge period
  logic mon_cpol = 1'b0, mon_cpha = 1'b0, mon_prev = 1'b0;
  logic [7:0] mon_byte = 8'd0;
  int cyc = 0, last_lead = 0, mon_period = 0;
  always @(negedge clk) begin
    cyc++;
    if (sck_o != mon_prev) begin
      if ((sck_o != mon_cpol) == !mon_cpha) mon_byte = {mon_byte[6:0], mosi_o};
      if (sck_o != mon_cpol) begin
        mon_period = cyc - last_lead;
        last_lead  = cyc;
      end
    end
    mon_prev = sck_o;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    bus_read(2'd1, d);
    bus_read(2'd2, d);
  endtask

  function automatic int div_of(input logic [2:0] code);
    case (code)
      3'd0: return 4;   3'd1: return 16;  3'd2: return 64;  3'd3: return 128;
      3'd4: return 2;   3'd5: return 8;   3'd6: return 32;  default: return 64;
    endcase
  endfunction

  task automatic test_reset();
    logic [7:0] d;
    check("R1 sck_o", sck_o, 1'b0);
    check("R1 irq", irq, 1'b0);
    bus_read(2'd0, d); check("R1 ctrl", d, 8'h00);
    bus_read(2'd1, d); check("R1 status", d, 8'h00);
  endtask

  task automatic master_xfer(input logic cpol, input logic cpha, input logic [2:0] code,
                             input logic [7:0] tx);
    logic [7:0] d;
    int div;
    div = div_of(code);
    mon_cpol = cpol; mon_cpha = cpha;
    bus_write(2'd1, {7'd0, code[2]});
    bus_write(2'd0, {1'b0, 1'b1, 1'b0, 1'b1, cpol, cpha, code[1:0]});
    wait_clk(3);
    check("R3 idle level before", sck_o, cpol);
    bus_write(2'd2, tx);
    wait_clk(div * 8 + 12);
    check("R4 bits on line", mon_byte, tx);
    check("R2 sck period", mon_period, div);
    check("R3 idle level after", sck_o, cpol);
    bus_read(2'd1, d); check("R5 completion flag", d, {1'b1, 6'd0, code[2]});
    bus_read(2'd2, d); check("R4 received byte", d, tx);
    bus_read(2'd1, d); check("R6 flags cleared", d, {7'd0, code[2]});
  endtask

  task automatic test_collision();
    logic [7:0] d;
    mon_cpol = 1'b0; mon_cpha = 1'b0;
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h53);
    bus_write(2'd2, 8'h3C);
    wait_clk(40);
    bus_write(2'd2, 8'hFF);
    wait_clk(128 * 8 + 12);
    check("R7 byte on line intact", mon_byte, 8'h3C);
    bus_read(2'd2, d); check("R7 received byte intact", d, 8'h3C);
    bus_read(2'd1, d); check("R6 data read alone keeps flags", d, 8'hC0);
    bus_read(2'd2, d);
    bus_read(2'd1, d); check("R6 both flags cleared", d, 8'h00);
  endtask

  task automatic test_status_bits();
    logic [7:0] d;
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, d); check("R8 reserved bits zero", d, 8'h01);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R8 double speed cleared", d, 8'h00);
  endtask

  task automatic test_irq();
    logic [7:0] d;
    bus_write(2'd0, 8'hD0);
    glob_irq_en = 1'b1;
    bus_write(2'd2, 8'h81);
    wait_clk(4 * 8 + 12);
    check("R9 irq raised", irq, 1'b1);
    glob_irq_en = 1'b0; wait_clk(2);
    check("R9 irq gated by global enable", irq, 1'b0);
    glob_irq_en = 1'b1; wait_clk(2);
    check("R9 irq back", irq, 1'b1);
    irq_ack = 1'b1; wait_clk(1); irq_ack = 1'b0; wait_clk(2);
    check("R9 irq after ack", irq, 1'b0);
    bus_read(2'd1, d); check("R9 ack cleared flag", d, 8'h00);
    glob_irq_en = 1'b0;
    bus_write(2'd0, 8'h50);
  endtask

  task automatic test_fault();
    logic [7:0] d;
    bus_write(2'd0, 8'h70);
    ss_n_i = 1'b0;
    wait_clk(6);
    bus_read(2'd0, d); check("R10 clock-driving bit dropped", d, 8'h60);
    bus_read(2'd1, d); check("R10 completion flag", d, 8'h80);
    check("R10 clock idle", sck_o, 1'b0);
    ss_n_i = 1'b1;
    wait_clk(4);
    bus_read(2'd2, d);
    bus_read(2'd1, d); check("R10 flag cleared", d, 8'h00);
  endtask

  // drive nbits as the remote clock source; returns bits seen on miso_o
  task automatic slave_bits(input logic cpol, input logic cpha, input logic [7:0] mo,
                            input int nbits, output logic [7:0] got);
    got = 8'd0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi_i = mo[i];
      wait_clk(8);
      if (!cpha) got = {got[6:0], miso_o};
      sck_i = ~cpol;
      wait_clk(8);
      if (cpha) got = {got[6:0], miso_o};
      sck_i = cpol;
      wait_clk(8);
    end
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic [7:0] pre,
                            input logic [7:0] mo);
    logic [7:0] d, got;
    sck_i = cpol;
    bus_write(2'd0, {4'b0100, cpol, cpha, 2'b11});
    wait_clk(4);
    bus_write(2'd2, pre);
    ss_n_i = 1'b0;
    wait_clk(8);
    slave_bits(cpol, cpha, mo, 8, got);
    ss_n_i = 1'b1;
    wait_clk(6);
    check("R11 byte sent on miso", got, pre);
    bus_read(2'd1, d); check("R11 completion flag", d, 8'h80);
    bus_read(2'd2, d); check("R11 byte received", d, mo);
    bus_read(2'd1, d); check("R11 flag cleared", d, 8'h00);
  endtask

  task automatic test_slave_abort();
    logic [7:0] d, got;
    sck_i = 1'b0;
    bus_write(2'd0, 8'h40);
    ss_n_i = 1'b0; wait_clk(8);
    slave_bits(1'b0, 1'b0, 8'hE0, 3, got);
    ss_n_i = 1'b1; wait_clk(8);
    bus_read(2'd1, d); check("R12 no flag on partial byte", d, 8'h00);
    ss_n_i = 1'b0; wait_clk(8);
    slave_bits(1'b0, 1'b0, 8'h5A, 8, got);
    ss_n_i = 1'b1; wait_clk(6);
    bus_read(2'd2, d); check("R12 realigned byte", d, 8'h5A);
    clear_flags();
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    test_reset();
    master_xfer(1'b0, 1'b0, 3'd0, 8'hA5);
    master_xfer(1'b1, 1'b1, 3'd1, 8'h3C);
    master_xfer(1'b0, 1'b1, 3'd4, 8'hC3);
    master_xfer(1'b1, 1'b0, 3'd5, 8'h96);
    for (int c = 2; c < 8; c++) begin
      if (c != 4 && c != 5) master_xfer(1'b0, 1'b0, 3'(c), 8'h69);
    end
    test_collision();
    test_status_bits();
    test_irq();
    test_fault();
    slave_xfer(1'b0, 1'b0, 8'hA5, 8'h1E);
    slave_xfer(1'b1, 1'b1, 8'h4B, 8'hD2);
    test_slave_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule